// File: doc/BRIEF.md
# Command Slot Issue Dispatcher

This block decides, for one storage port, which outstanding non-queued command slot goes to the device next. It also decides when that slot's issue bit may be retired. A register file elsewhere owns the 32-bit command issue vector. The dispatcher watches that vector, the port's start bit and the device status flags (busy, data request, error). It emits a one-cycle dispatch strobe with the chosen slot number and keeps a record of the single slot currently in flight. When the device reports completion, it sends the register file a one-cycle clear mask.

At most one non-queued slot is in flight at a time. The scan runs only when a scan request is pending: a request is raised whenever a new issue bit appears, or one cycle after a clean completion that leaves issue bits standing. The issue bit of a finished command is removed only if the device status at completion shows no error and neither busy nor data request. A completion that reports an error schedules no further scan, so the port stays quiet until software adds new work.

Top module: `cmd_slot_dispatcher`

## Requirements
- R1: A scan dispatches nothing unless `start_en` is 1 and `issue_vec` is nonzero. A pending scan request that meets a cleared start bit or an empty vector, while no slot is busy, is dropped.
- R2: The dispatched slot is the lowest-numbered set bit of `issue_vec`, with bit n meaning slot n (slot 0 has the highest priority).
- R3: No dispatch happens in a cycle where `dev_busy` or `dev_drq` is 1. The scan request stays pending and dispatch follows once both are 0.
- R4: `busy_slot` (6 bits) holds the dispatched slot number while a command is in flight. It holds all ones (value -1, idle) after `rst`, after `port_reset` and after any accepted completion.
- R5: A `cmd_done` accepted while a slot is busy drives `clr_mask` in the next cycle to a one-hot mask of that slot when `dev_err`, `dev_busy` and `dev_drq` are all 0, and to zero otherwise. `clr_mask` is zero in every other cycle.
- R6: After a completion with `dev_err` at 0, if issue bits remain once the cleared bit is discounted, a rescan dispatches one cycle after `clr_mask` is shown. That scan uses the vector as updated by the register file.
- R7: A completion with `dev_err` at 1 schedules no rescan. No dispatch follows until a new issue bit appears.
- R8: A 0-to-1 change of any `issue_vec` bit raises a scan request. The request is held while a slot is busy and is served after the slot is released.
- R9: No dispatch occurs while `busy_slot` holds a valid slot.
- R10: `cmd_done` while no slot is busy has no effect: `clr_mask` stays zero and no scan is scheduled.
- R11: `disp_valid` is a one-cycle pulse. `busy_slot` equals `disp_slot` in the cycle it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_reset | input | 1 | Port-level reset; releases the busy slot and drops pending scans |
| start_en | input | 1 | Port command engine start bit |
| issue_vec | input | 32 | Command issue vector from the register file |
| dev_busy | input | 1 | Device busy status |
| dev_drq | input | 1 | Device data request status |
| dev_err | input | 1 | Device error status |
| cmd_done | input | 1 | Completion strobe for the in-flight command |
| disp_valid | output | 1 | One-cycle dispatch request |
| disp_slot | output | 5 | Slot number carried by the dispatch request |
| busy_slot | output | 6 | In-flight slot, all ones when idle |
| clr_mask | output | 32 | One-cycle mask of issue bits the register file must clear |

## Verification
Directed vectors with several set bits, including a new lower-numbered bit added while a slot is busy, show whether the lowest set bit wins and whether a held request waits for the slot to be released. Completions are tried under each status: clean, busy asserted and error asserted. These separate retiring the slot from releasing it, and separate a rescan from a quiet port. A completion strobe while idle and a port reset with issue bits still set show that neither produces stray clears or dispatches. A long seeded random phase mixes sparse and dense issue patterns, start drops and status noise, and compares every output in every cycle against a bench model.

// File: rtl/cmd_dispatch_pkg.sv
package cmd_dispatch_pkg;
  typedef struct packed {
    logic busy;
    logic drq;
    logic err;
  } dev_stat_t;

  function automatic logic dev_quiet(input dev_stat_t s);
    return !s.busy && !s.drq;
  endfunction

  function automatic logic dev_clean(input dev_stat_t s);
    return !s.busy && !s.drq && !s.err;
  endfunction
endpackage

// File: rtl/slot_pick.sv
module slot_pick #(
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_W    = 5
) (
  input  logic [NUM_SLOTS-1:0] vec,
  output logic                 found,
  output logic [SLOT_W-1:0]    idx
);
  logic [NUM_SLOTS:0]   seen;
  logic [NUM_SLOTS-1:0] first;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chain
    assign seen[i+1] = seen[i] | vec[i];
    assign first[i]  = vec[i] & ~seen[i];
  end

  assign found = seen[NUM_SLOTS];

  always_comb begin
    idx = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (first[k]) idx = idx | SLOT_W'(k);
    end
  end

  // R2: exactly one winner whenever any bit is set
  always_comb begin
    if (found) begin
      assert_single_pick_R2: assert ($onehot(first));
    end
  end
endmodule

// File: rtl/busy_tracker.sv
module busy_tracker
  import cmd_dispatch_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 port_reset,
  input  logic                 fire,
  input  logic [SLOT_W-1:0]    fire_slot,
  input  logic                 cmd_done,
  input  dev_stat_t            stat,
  output logic [SLOT_W:0]      busy_slot,
  output logic                 busy_ok,
  output logic                 done_acc,
  output logic [NUM_SLOTS-1:0] clr_bits,
  output logic [NUM_SLOTS-1:0] clr_mask
);
  localparam int BW = SLOT_W + 1;
  localparam logic [BW-1:0] IDLE = '1;

  logic in_range;

  if (NUM_SLOTS == (1 << SLOT_W)) begin : g_full
    assign in_range = 1'b1;
  end else begin : g_part
    assign in_range = ({1'b0, busy_slot[SLOT_W-1:0]} < BW'(NUM_SLOTS));
  end

  assign busy_ok  = !busy_slot[BW-1] && in_range;
  assign done_acc = cmd_done && busy_ok;
  assign clr_bits = (done_acc && dev_clean(stat))
                    ? (NUM_SLOTS'(1) << busy_slot[SLOT_W-1:0]) : '0;

  always_ff @(posedge clk) begin
    if (rst || port_reset) begin
      busy_slot <= IDLE;
      clr_mask  <= '0;
    end else begin
      clr_mask <= clr_bits;
      if (done_acc)  busy_slot <= IDLE;
      else if (fire) busy_slot <= {1'b0, fire_slot};
    end
  end

  // R4: an invalid slot is always the all-ones code
  assert_busy_enc_R4: assert property (@(posedge clk) disable iff (rst)
    busy_slot[BW-1] |-> (&busy_slot));

  // R5: a clear pulse only follows a busy slot
  assert_clr_needs_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (|clr_mask) |-> $past(busy_ok));

  // R5: clear mask never names more than one slot
  assert_clr_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr_mask));
endmodule

// File: rtl/scan_sched.sv
module scan_sched (
  input  logic clk,
  input  logic rst,
  input  logic port_reset,
  input  logic set_req,
  input  logic fire,
  input  logic drop,
  output logic scan_req
);
  always_ff @(posedge clk) begin
    if (rst || port_reset)   scan_req <= 1'b0;
    else if (set_req)        scan_req <= 1'b1;
    else if (fire || drop)   scan_req <= 1'b0;
  end

  // R8: a scan request raised outside a reset is held
  assert_req_raise_R8: assert property (@(posedge clk) disable iff (rst)
    (set_req && !port_reset) |=> scan_req);
endmodule

// File: rtl/cmd_slot_dispatcher.sv
module cmd_slot_dispatcher
  import cmd_dispatch_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 port_reset,
  input  logic                 start_en,
  input  logic [NUM_SLOTS-1:0] issue_vec,
  input  logic                 dev_busy,
  input  logic                 dev_drq,
  input  logic                 dev_err,
  input  logic                 cmd_done,
  output logic                 disp_valid,
  output logic [SLOT_W-1:0]    disp_slot,
  output logic [SLOT_W:0]      busy_slot,
  output logic [NUM_SLOTS-1:0] clr_mask
);
  dev_stat_t stat;
  assign stat = '{busy: dev_busy, drq: dev_drq, err: dev_err};

  logic [NUM_SLOTS-1:0] issue_prev;
  logic [NUM_SLOTS-1:0] clr_bits;
  logic                 pick_found;
  logic [SLOT_W-1:0]    pick_idx;
  logic                 busy_ok, done_acc, scan_req;
  logic                 fire, drop, rescan, new_any, set_req;

  slot_pick #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_pick (
    .vec   (issue_vec),
    .found (pick_found),
    .idx   (pick_idx)
  );

  assign fire = scan_req && !busy_ok && start_en && pick_found && dev_quiet(stat);
  assign drop = scan_req && !busy_ok && (!start_en || !pick_found);

  busy_tracker #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .port_reset(port_reset),
    .fire      (fire),
    .fire_slot (pick_idx),
    .cmd_done  (cmd_done),
    .stat      (stat),
    .busy_slot (busy_slot),
    .busy_ok   (busy_ok),
    .done_acc  (done_acc),
    .clr_bits  (clr_bits),
    .clr_mask  (clr_mask)
  );

  assign new_any = |(issue_vec & ~issue_prev);
  assign rescan  = done_acc && !dev_err && (|(issue_vec & ~clr_bits));
  assign set_req = new_any || rescan;

  scan_sched u_sched (
    .clk       (clk),
    .rst       (rst),
    .port_reset(port_reset),
    .set_req   (set_req),
    .fire      (fire),
    .drop      (drop),
    .scan_req  (scan_req)
  );

  always_ff @(posedge clk) begin
    if (rst) issue_prev <= '0;
    else     issue_prev <= issue_vec;
  end

  always_ff @(posedge clk) begin
    if (rst || port_reset) begin
      disp_valid <= 1'b0;
      disp_slot  <= '0;
    end else begin
      disp_valid <= fire;
      if (fire) disp_slot <= pick_idx;
    end
  end

  // R1: dispatch only with start set and work present
  assert_disp_work_R1: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> ($past(start_en) && $past(|issue_vec)));

  // R3: no dispatch while the device is busy or requesting data
  assert_disp_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> ($past(!dev_busy) && $past(!dev_drq)));

  // R11: the dispatch strobe lasts one cycle
  assert_disp_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    disp_valid |=> !disp_valid);

  // R11: the recorded busy slot matches the dispatched slot
  assert_disp_match_R11: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> (busy_slot == {1'b0, disp_slot}));

  // R9: a new dispatch never overlaps a slot in flight
  assert_one_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && !$past(port_reset)) |-> $past(busy_slot[SLOT_W]));
endmodule

// File: tb/cmd_slot_dispatcher_test.sv
`timescale 1ns/1ps
module cmd_slot_dispatcher_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prst = 1'b0;
  logic        start = 1'b0;
  logic [31:0] issue = '0;
  logic        dbusy = 1'b0, ddrq = 1'b0, derr = 1'b0, done = 1'b0;
  logic        disp_valid;
  logic [4:0]  disp_slot;
  logic [5:0]  busy_slot;
  logic [31:0] clr_mask;

  int total = 0;
  int bad   = 0;

  // bench reference state
  int          m_busy = -1;
  bit          m_scan = 1'b0;
  logic [31:0] m_prev = '0;
  bit          e_dv = 1'b0;
  int          e_ds = 0;
  logic [31:0] e_clr = '0;

  always #5 clk = ~clk;

  cmd_slot_dispatcher uut (
    .clk(clk), .rst(rst), .port_reset(prst), .start_en(start),
    .issue_vec(issue), .dev_busy(dbusy), .dev_drq(ddrq), .dev_err(derr),
    .cmd_done(done), .disp_valid(disp_valid), .disp_slot(disp_slot),
    .busy_slot(busy_slot), .clr_mask(clr_mask)
  );

  function automatic int lowest(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit fire, drop, dacc, resc, setr, bok;
    logic [31:0] cb;
    bok = (m_busy >= 0);
    if (rst) begin
      m_busy = -1; m_scan = 0; e_dv = 0; e_clr = '0; m_prev = '0;
    end else if (prst) begin
      m_busy = -1; m_scan = 0; e_dv = 0; e_clr = '0; m_prev = issue;
    end else begin
      fire = m_scan && !bok && start && (issue != 0) && !dbusy && !ddrq;
      drop = m_scan && !bok && (!start || issue == 0);
      dacc = done && bok;
      cb   = (dacc && !derr && !dbusy && !ddrq) ? (32'd1 << m_busy) : '0;
      resc = dacc && !derr && ((issue & ~cb) != 0);
      setr = resc || ((issue & ~m_prev) != 0);
      e_dv  = fire;
      e_clr = cb;
      if (fire) e_ds = lowest(issue);
      if (dacc) m_busy = -1;
      else if (fire) m_busy = lowest(issue);
      if (setr) m_scan = 1;
      else if (fire || drop) m_scan = 0;
      m_prev = issue;
    end
  endtask

  // one clock: predict, advance, compare, apply the register-file clear
  task automatic tick();
    logic [5:0] eb;
    model_step();
    @(posedge clk);
    @(negedge clk);
    eb = (m_busy < 0) ? 6'h3F : 6'(m_busy);
    check("R11 dispatch strobe", 32'(disp_valid), 32'(e_dv));
    if (e_dv) check("R2 dispatched slot", 32'(disp_slot), 32'(e_ds));
    check("R4 busy slot", 32'(busy_slot), 32'(eb));
    check("R5 clear mask", clr_mask, e_clr);
    issue = issue & ~e_clr;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5EED_1234));
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    tick();
    check("R4 reset busy idle", 32'(busy_slot), 32'h3F);
    check("R4 reset no dispatch", 32'(disp_valid), 0);
    check("R5 reset no clear", clr_mask, 0);

    // R1: work without start is not dispatched
    issue = 32'h0000_0100; start = 1'b0;
    tick(); tick(); tick();
    check("R1 no scan without start", 32'(disp_valid), 0);
    start = 1'b1;
    tick(); tick();
    check("R1 stale request dropped", 32'(disp_valid), 0);

    // R2: lowest set bit wins
    issue = 32'h8000_0300;
    tick();
    check("R8 request only, no dispatch yet", 32'(disp_valid), 0);
    tick();
    check("R2 dispatch strobe", 32'(disp_valid), 1);
    check("R2 lowest slot 8", 32'(disp_slot), 8);
    check("R4 busy holds 8", 32'(busy_slot), 8);

    // R9/R11: new lower bit while busy is held
    issue = issue | 32'h4;
    tick();
    check("R11 strobe one cycle", 32'(disp_valid), 0);
    tick();
    check("R9 no dispatch while busy", 32'(disp_valid), 0);

    // R5/R6: clean completion, then rescan
    done = 1'b1;
    tick();
    done = 1'b0;
    check("R5 clear slot 8", clr_mask, 32'h100);
    check("R4 busy released", 32'(busy_slot), 32'h3F);
    tick();
    check("R6 rescan dispatch", 32'(disp_valid), 1);
    check("R6 rescan picks slot 2", 32'(disp_slot), 2);

    // R3/R5: completion under busy keeps the bit; busy blocks dispatch
    done = 1'b1; dbusy = 1'b1;
    tick();
    done = 1'b0;
    check("R5 no clear under busy", clr_mask, 0);
    tick(); tick(); tick();
    check("R3 no dispatch under busy", 32'(disp_valid), 0);
    dbusy = 1'b0; ddrq = 1'b1;
    tick();
    check("R3 no dispatch under drq", 32'(disp_valid), 0);
    ddrq = 1'b0;
    tick();
    check("R3 dispatch after release", 32'(disp_valid), 1);
    check("R3 slot 2 retained", 32'(disp_slot), 2);

    // R7: error completion stops the port
    done = 1'b1; derr = 1'b1;
    tick();
    done = 1'b0; derr = 1'b0;
    check("R7 no clear on error", clr_mask, 0);
    tick(); tick(); tick();
    check("R7 no rescan after error", 32'(disp_valid), 0);
    issue = issue | 32'h0010_0000;
    tick(); tick();
    check("R8 new bit restarts", 32'(disp_valid), 1);
    check("R8 slot 2 again", 32'(disp_slot), 2);

    // drain two slots, then port reset and idle completion
    done = 1'b1; tick(); done = 1'b0;
    check("R5 clear slot 2", clr_mask, 32'h4);
    tick();
    check("R6 next slot 9", 32'(disp_slot), 9);
    done = 1'b1; tick(); done = 1'b0;
    tick();
    check("R6 next slot 20", 32'(disp_slot), 20);
    prst = 1'b1; tick(); prst = 1'b0;
    check("R4 port reset idles", 32'(busy_slot), 32'h3F);
    done = 1'b1; tick(); done = 1'b0;
    check("R10 idle done no clear", clr_mask, 0);
    tick();
    check("R10 idle done no scan", 32'(disp_valid), 0);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      start = ($urandom % 100) >= 3;
      if (!start) issue = '0;
      if ($urandom % 6 == 0) issue = issue | (32'd1 << ($urandom % 32));
      if ($urandom % 50 == 0) issue = issue | $urandom;
      if (!start) issue = '0;
      dbusy = ($urandom % 5 == 0);
      ddrq  = ($urandom % 8 == 0);
      derr  = ($urandom % 10 == 0);
      done  = (m_busy >= 0) ? ($urandom % 4 == 0) : ($urandom % 20 == 0);
      prst  = ($urandom % 200 == 0);
      tick();
    end
    done = 1'b0; prst = 1'b0;
    tick();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule